// File: doc/BRIEF.md
# Vertical-Blank NMI Generator

This block raises a non-maskable interrupt request when a raster timing chain enters vertical blanking. It watches the vertical line counter, which passes through a short delay pipeline first. Every fourth master clock it compares that counter against a programmable display height. A software-visible blanking flag follows the compare result. The flag is set on entry to blanking and cleared on exit.

Software can clear the flag by reading it. For one evaluation period after the flag is set, a hold bit protects it from that clear. When the hold bit drops and the interrupt is enabled, a request is latched. A request is also latched when software turns the enable on while the flag is already set.

A latched request stays pending until the processor reports the last cycle of an instruction. The block then emits a one-clock pulse that starts the interrupt and wakes a processor that is waiting for an interrupt.

Top module: `nmi_vblank_gen`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, flag_o and take_o are 0; the enable, hold and pending request are clear and the counter pipeline holds zero.
- R2: The compare is evaluated only on every fourth clock, counted from reset release. flag_o changes from the compare only on the clock edge that ends such an evaluation cycle.
- R3: The blanking condition is true when vcount_i, delayed by two clocks, is greater than or equal to vdisp_i. When the condition changes at an evaluation, flag_o takes the new value.
- R4: When flag_o is set, a hold bit is set with it and lasts until the next evaluation. While the hold bit is set, stat_rd_i does not clear flag_o.
- R5: When the hold bit is clear, a one-cycle stat_rd_i pulse clears flag_o on the next edge. A change in the blanking condition at the same edge overrides this clear.
- R6: At the evaluation where the hold bit drops, a request is latched if the enable is set. The request is consumed on a clock where insn_last_i is 1, and take_o is 1 on the following cycle for exactly one clock.
- R7: A write with ctrl_we_i=1 loads the enable from ctrl_wdata_i bit 7. If this write turns the enable from 0 to 1 while flag_o is 1, a request is latched.
- R8: When the hold bit drops while the enable is 0, no request is latched.
- R9: A latched request stays pending with take_o at 0 for as long as insn_last_i stays at 0. Each request produces only one take_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| vcount_i | input | V_W | current vertical line counter |
| vdisp_i | input | V_W | first line of vertical blanking (display height) |
| ctrl_we_i | input | 1 | control register write strobe |
| ctrl_wdata_i | input | 8 | control write data; bit 7 is the interrupt enable |
| stat_rd_i | input | 1 | status read strobe; clears the flag unless held |
| insn_last_i | input | 1 | last cycle of the current instruction |
| flag_o | output | 1 | blanking status flag, also the value returned by a status read |
| take_o | output | 1 | one-clock interrupt start and wait release pulse |

## Verification
The hardest case to reach from the ports is the hold window. Here a status read arrives in the same short period in which the flag has just been set. The request must then come from the hold bit falling, and it must not come from the read. The bench reaches this case by holding the read strobe high across entry into blanking, with the processor boundary input held low. It then counts how many cycles the flag survives before the read clears it. Next it releases the boundary input after a long wait, to show that the request stayed pending and is taken only once. The bench also moves the counter at different offsets to the four-clock cadence, to check where the flag rises. A long run with random inputs then exercises a read, a write and an evaluation falling on the same edge.

// File: rtl/nmi_vblank_pkg.sv
package nmi_vblank_pkg;
  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned CTRL_EN_BIT = 7;
  localparam int unsigned EVAL_DIV    = 4;
  localparam int unsigned VDLY_DEPTH  = 2;
endpackage

// File: rtl/nmi_tick_div.sv
module nmi_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/nmi_vdelay.sv
module nmi_vdelay #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= '0;
      else         stage_q[i] <= (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/nmi_vblank_det.sv
module nmi_vblank_det #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] vdly_i,
  input  logic [W-1:0] vdisp_i,
  input  logic         rd_i,
  output logic         flag_o,
  output logic         hold_o,
  output logic         hold_fall_o
);
  logic in_blank, valid_q, flag_q, hold_q;
  logic valid_d, flag_d, hold_d;

  assign in_blank = (vdly_i >= vdisp_i);

  always_comb begin
    valid_d = valid_q;
    flag_d  = flag_q;
    hold_d  = hold_q;
    if (rd_i && !hold_q) flag_d = 1'b0;
    if (tick_i) begin
      hold_d = 1'b0;
      if (in_blank != valid_q) begin
        valid_d = in_blank;
        flag_d  = in_blank;
        hold_d  = in_blank;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      flag_q  <= flag_d;
      hold_q  <= hold_d;
    end
  end

  assign flag_o      = flag_q;
  assign hold_o      = hold_q;
  assign hold_fall_o = tick_i & hold_q;
endmodule

// File: rtl/nmi_req.sv
module nmi_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_fall_i,
  input  logic flag_i,
  input  logic en_we_i,
  input  logic en_wbit_i,
  input  logic insn_last_i,
  output logic en_o,
  output logic pend_o,
  output logic take_o
);
  logic en_q, pend_q, take_q;
  logic set_req, consume;

  assign set_req = (hold_fall_i & en_q) | (en_we_i & en_wbit_i & ~en_q & flag_i);
  assign consume = insn_last_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wbit_i;
      pend_q <= (pend_q & ~consume) | set_req;
      take_q <= consume;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign take_o = take_q;
endmodule

// File: rtl/nmi_vblank_gen.sv
module nmi_vblank_gen
  import nmi_vblank_pkg::*;
#(
  parameter int unsigned V_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [V_W-1:0]    vcount_i,
  input  logic [V_W-1:0]    vdisp_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              stat_rd_i,
  input  logic              insn_last_i,
  output logic              flag_o,
  output logic              take_o
);
  logic           tick;
  logic [V_W-1:0] vdly;
  logic           hold_q, hold_fall, en_q, pend_q;
  logic           unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata_i[CTRL_EN_BIT-1:0]};

  nmi_tick_div #(.DIV(EVAL_DIV)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  nmi_vdelay #(.W(V_W), .DEPTH(VDLY_DEPTH)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vcount_i), .q_o(vdly)
  );

  nmi_vblank_det #(.W(V_W)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .vdly_i     (vdly),
    .vdisp_i    (vdisp_i),
    .rd_i       (stat_rd_i),
    .flag_o     (flag_o),
    .hold_o     (hold_q),
    .hold_fall_o(hold_fall)
  );

  nmi_req u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_fall_i(hold_fall),
    .flag_i     (flag_o),
    .en_we_i    (ctrl_we_i),
    .en_wbit_i  (ctrl_wdata_i[CTRL_EN_BIT]),
    .insn_last_i(insn_last_i),
    .en_o       (en_q),
    .pend_o     (pend_q),
    .take_o     (take_o)
  );
endmodule

// File: rtl/nmi_vblank_chk.sv
module nmi_vblank_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic hold_q,
  input logic en_q,
  input logic pend_q,
  input logic stat_rd_i,
  input logic ctrl_we_i,
  input logic en_bit,
  input logic insn_last_i,
  input logic flag_o,
  input logic take_o
);
  AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(tick)); // R2

  AST_HOLD_BLOCKS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && flag_o && stat_rd_i && !tick) |=> flag_o); // R4

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && stat_rd_i && !tick) |=> !flag_o); // R5

  AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(insn_last_i) && $past(pend_q)); // R6

  AST_ENABLE_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && en_bit && !en_q && flag_o) |=> pend_q); // R7

  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !en_q && !ctrl_we_i) |=> !pend_q); // R8

  AST_PEND_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !insn_last_i) |=> pend_q && !take_o); // R9
endmodule

bind nmi_vblank_gen nmi_vblank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick       (tick),
  .hold_q     (hold_q),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .stat_rd_i  (stat_rd_i),
  .ctrl_we_i  (ctrl_we_i),
  .en_bit     (ctrl_wdata_i[7]),
  .insn_last_i(insn_last_i),
  .flag_o     (flag_o),
  .take_o     (take_o)
);

// File: tb/tb_nmi_vblank_gen.sv
module tb_nmi_vblank_gen;
  localparam int CLK_PERIOD = 10;
  localparam int V_W = 9;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [V_W-1:0] vcount_i = '0;
  logic [V_W-1:0] vdisp_i = 9'd10;
  logic           ctrl_we_i = 1'b0;
  logic [7:0]     ctrl_wdata_i = '0;
  logic           stat_rd_i = 1'b0;
  logic           insn_last_i = 1'b0;
  logic           flag_o, take_o;

  int tests = 0, fails = 0, takes = 0;
  bit done = 0;

  // reference model state
  int m_phase;
  int m_vq[$];
  bit m_flag, m_hold, m_valid, m_en, m_tr, m_take;

  nmi_vblank_gen #(.V_W(V_W)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_vq = '{0, 0};
    m_flag = 0; m_hold = 0; m_valid = 0; m_en = 0; m_tr = 0; m_take = 0;
  endtask

  task automatic model_edge();
    bit tick, nf, nh, nv, set_tr, vb, cons;
    int dv;
    tick = (m_phase == 3);
    m_phase = (m_phase + 1) % 4;
    dv = m_vq.pop_front();
    m_vq.push_back(int'(vcount_i));
    nf = m_flag; nh = m_hold; nv = m_valid; set_tr = 0;
    if (stat_rd_i && !m_hold) nf = 0;
    if (tick) begin
      if (m_hold) begin nh = 0; if (m_en) set_tr = 1; end
      vb = (dv >= int'(vdisp_i));
      if (vb != m_valid) begin nv = vb; nf = vb; if (vb) nh = 1; end
    end
    if (ctrl_we_i) begin
      if (!m_en && ctrl_wdata_i[7] && m_flag) set_tr = 1;
      m_en = ctrl_wdata_i[7];
    end
    cons = insn_last_i && m_tr;
    m_take = cons;
    m_tr = (m_tr && !cons) || set_tr;
    m_flag = nf; m_hold = nh; m_valid = nv;
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check("R3 flag_o vs model", int'(flag_o), int'(m_flag));
    check("R6 take_o vs model", int'(take_o), int'(m_take));
    if (take_o) takes++;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic write_en(bit v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = {v, 7'h15};
    cyc();
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
  endtask

  task automatic rise_delay(int pre);
    int d;
    vcount_i = '0; wait_n(16 + pre);
    vcount_i = 9'd20;
    d = 0;
    for (int i = 0; i < 10 && !flag_o; i++) begin cyc(); d++; end
    tests++;
    if (d < 3 || d > 6) begin
      fails++;
      $display("FAIL R2 rise delay actual=%0d expected=3..6", d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ones;
    model_reset();
    #(CLK_PERIOD * 3);
    check("R1 flag_o in reset", int'(flag_o), 0);
    check("R1 take_o in reset", int'(take_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc();
    check("R1 flag_o after reset", int'(flag_o), 0);

    // enable off: blanking entered, no request
    insn_last_i = 1'b1; takes = 0;
    vcount_i = 9'd20; wait_n(16);
    check("R3 flag set in blanking", int'(flag_o), 1);
    check("R8 no take while disabled", takes, 0);

    stat_rd_i = 1'b1; cyc(); stat_rd_i = 1'b0;
    check("R5 read clears flag", int'(flag_o), 0);

    vcount_i = 9'd0; wait_n(16);
    check("R3 flag low after exit", int'(flag_o), 0);
    vcount_i = 9'd20; wait_n(16);
    check("R8 still no take", takes, 0);
    takes = 0;
    write_en(1'b1); wait_n(6);
    check("R7 enable rise with flag set", takes, 1);

    // hold window with continuous reads
    vcount_i = 9'd0; wait_n(16);
    takes = 0;
    write_en(1'b1); wait_n(4);
    check("R7 no take when flag clear", takes, 0);
    insn_last_i = 1'b0;
    stat_rd_i = 1'b1;
    vcount_i = 9'd20;
    for (int i = 0; i < 12 && !flag_o; i++) cyc();
    ones = 0;
    while (flag_o && ones < 10) begin ones++; cyc(); end
    stat_rd_i = 1'b0;
    check("R4 flag survives hold window", ones, 5);
    check("R5 flag cleared after hold", int'(flag_o), 0);
    wait_n(20);
    check("R9 pending waits for boundary", takes, 0);
    insn_last_i = 1'b1; cyc(); insn_last_i = 1'b0;
    wait_n(5);
    check("R6 one take after boundary", takes, 1);
    insn_last_i = 1'b1; wait_n(8); insn_last_i = 1'b0;
    check("R9 single pulse per request", takes, 1);

    rise_delay(0);
    rise_delay(1);
    rise_delay(2);
    rise_delay(3);

    // random traffic with per-cycle model compare
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) vcount_i = V_W'($urandom_range(0, 24));
      if ($urandom_range(0, 199) == 0) vdisp_i = V_W'($urandom_range(4, 20));
      stat_rd_i    = ($urandom_range(0, 5) == 0);
      insn_last_i  = ($urandom_range(0, 2) == 0);
      ctrl_we_i    = ($urandom_range(0, 15) == 0);
      ctrl_wdata_i = 8'($urandom);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule